// File: doc/BRIEF.md
# Coprocessor Command Status Controller

This block sits at the command port of a floating-point coprocessor. It accepts one 12-bit opcode and a 32-bit operand per strobe. It sorts each opcode into a command kind, and it keeps the coprocessor's status word and mode field up to date. Three control commands act on that state:

- a status-restore command that rebuilds the status word from the operand;
- a mode-load command that writes the low mode field after a range check on the operand;
- an init command that is kept only so that older software still runs, and does nothing.

Opcodes are tested against a parameterised list of value/mask pairs. An opcode that matches any pair is unimplemented. Such an opcode, or a mode operand that is out of range, latches a fault. The block then stays in a hang state until the pipe is cleared.

Every accepted strobe is first captured into a one-entry stage and then executed on the following clock edge. `busy` is high for that one execute cycle and for as long as the block is hung. A strobe that arrives while `busy` is high is dropped. All opcodes that are neither control commands nor invalid belong to the arithmetic datapath, so here they pass through with no effect.

Top module: `cpcmd_ctrl`

## Requirements
- R1: After reset, `status_q` and `mode_q` are zero, and `busy` and `hang` are low.
- R2: Opcode 0x256 (restore) sets `status_q` to {operand[11:8], 1'b0, 1'b1}. Status bit 0 is the valid flag, bit 1 is the unimplemented flag, and bits 5:2 hold operand bits 11:8.
- R3: Opcode 0x25E (init) leaves `status_q`, `mode_q` and `hang` unchanged.
- R4: Opcodes 0x234 and 0x235 (mode load) write operand[3:0] into `mode_q`, but only when the full 32-bit operand is at least 1 and at most MAX_MODE (default 7).
- R5: A mode-load operand of zero or above MAX_MODE leaves `mode_q` and `status_q` unchanged and raises `hang`.
- R6: An opcode in the invalid list sets status bit 1 and raises `hang`. The other status bits and `mode_q` are left unchanged.
- R7: The default invalid list always covers 0x3BE/0x3BF (pattern 00111011111x). It also covers the classes 1010xxxxxxxx, x01111xxxxxx, 10111000xxxx, 10111001xxxx and 100xxxxxxxx0.
- R8: While `hang` is high, `busy` is high and every strobe is ignored. A one-cycle `clr_pipe` pulse drops `hang` and `busy` and keeps `status_q` and `mode_q`. A `clr_pipe` pulse during the execute cycle cancels the captured command.
- R9: An opcode that is neither a control command nor invalid, for example 0x803, has no effect on `status_q`, `mode_q` or `hang`.
- R10: A strobe taken while `busy` is low raises `busy` after the capture edge. Its effect is visible after the next edge. A strobe presented while `busy` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode strobe |
| cmd_op | input | 12 | Command opcode |
| cmd_arg | input | 32 | Command operand |
| clr_pipe | input | 1 | Clears a hang or a command in flight |
| status_q | output | 6 | Status word: flags[5:2], unimplemented[1], valid[0] |
| mode_q | output | 4 | Mode field bits 3:0 |
| busy | output | 1 | Executing or hung; strobes ignored |
| hang | output | 1 | Fault latched |

## Verification
The bench probes the edges of the mode range:

- Operands 0, 1, MAX_MODE and MAX_MODE+1 are tested. A design with an off-by-one compare would either reject a legal mode or accept a bad one without hanging.
- The operand 0x00010001 is also tested. A design that compared only the low nibble would load mode 1 instead of hanging.

Each protected opcode is driven with both values of its don't-care bit. So are neighbouring opcodes that differ only in the masked bit of a class. A wrong mask would either let 0x3BF through or flag the harmless 0x803.

The remaining tests target the hang state and the stage:

- Strobes are sent while the block is hung, and back to back during the execute cycle. A design that leaked these commands would change status.
- `clr_pipe` is pulsed in the execute cycle. A design that ignored it there would still apply the captured command.

// File: rtl/cpcmd_pkg.sv
package cpcmd_pkg;

  localparam int OP_W = 12;

  // status word field positions
  localparam int ST_VALID  = 0;
  localparam int ST_UNIMPL = 1;

  // command opcodes
  localparam logic [OP_W-1:0] OP_INIT    = 12'h25E;
  localparam logic [OP_W-1:0] OP_RESTORE = 12'h256;
  localparam logic [OP_W-1:0] OP_LDMODE  = 12'h234; // bit 0 is don't-care
  localparam logic [OP_W-1:0] LDMODE_MSK = 12'hFFE;

  typedef enum logic [2:0] {
    K_OTHER   = 3'd0,
    K_INIT    = 3'd1,
    K_RESTORE = 3'd2,
    K_LDMODE  = 3'd3,
    K_INVALID = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXEC = 2'd1,
    S_HANG = 2'd2
  } state_e;

  localparam int DEF_NPAT = 10;

  // value / mask pairs: a mask bit of 1 must match
  localparam logic [DEF_NPAT-1:0][OP_W-1:0] DEF_INV_VAL = {
    12'h760, 12'hC00, 12'h270, 12'h294, 12'h800,
    12'hB90, 12'hB80, 12'h3C0, 12'hA00, 12'h3BE
  };
  localparam logic [DEF_NPAT-1:0][OP_W-1:0] DEF_INV_MSK = {
    12'hFE0, 12'hFFF, 12'hFFF, 12'hFFE, 12'hE01,
    12'hFF0, 12'hFF0, 12'h7C0, 12'hF00, 12'hFFE
  };

endpackage

// File: rtl/cpcmd_classify.sv
module cpcmd_classify
  import cpcmd_pkg::*;
#(
  parameter int NPAT = DEF_NPAT,
  parameter logic [NPAT-1:0][OP_W-1:0] INV_VAL = DEF_INV_VAL,
  parameter logic [NPAT-1:0][OP_W-1:0] INV_MSK = DEF_INV_MSK
) (
  input  logic [OP_W-1:0] op,
  output kind_e           kind
);

  logic [NPAT-1:0] hit;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign hit[g] = ((op ^ INV_VAL[g]) & INV_MSK[g]) == '0;
  end

  always_comb begin
    if (|hit)
      kind = K_INVALID;
    else if (op == OP_RESTORE)
      kind = K_RESTORE;
    else if (op == OP_INIT)
      kind = K_INIT;
    else if ((op & LDMODE_MSK) == OP_LDMODE)
      kind = K_LDMODE;
    else
      kind = K_OTHER;
  end

endmodule

// File: rtl/cpcmd_fsm.sv
module cpcmd_fsm
  import cpcmd_pkg::*;
#(
  parameter int ARG_W    = 32,
  parameter int MAX_MODE = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  kind_e            kind_in,
  input  logic [ARG_W-1:0] arg_in,
  input  logic             clr_pipe,
  output logic [ARG_W-1:0] arg_q,
  output logic             do_restore,
  output logic             do_mode,
  output logic             do_unimpl,
  output logic             busy,
  output logic             hang
);

  localparam logic [ARG_W-1:0] MAX_A = ARG_W'(MAX_MODE);

  state_e state_q, state_d;
  kind_e  kind_q;
  logic   cap_en, exec, range_ok, fault;

  assign cap_en   = (state_q == S_IDLE) && cmd_valid && !clr_pipe;
  assign exec     = (state_q == S_EXEC) && !clr_pipe;
  assign range_ok = (arg_q != '0) && (arg_q <= MAX_A);
  assign fault    = (kind_q == K_INVALID) || ((kind_q == K_LDMODE) && !range_ok);

  assign do_restore = exec && (kind_q == K_RESTORE);
  assign do_mode    = exec && (kind_q == K_LDMODE) && range_ok;
  assign do_unimpl  = exec && (kind_q == K_INVALID);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (cap_en) state_d = S_EXEC;
      S_EXEC:  if (clr_pipe) state_d = S_IDLE;
               else if (fault) state_d = S_HANG;
               else state_d = S_IDLE;
      S_HANG:  if (clr_pipe) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_OTHER;
      arg_q  <= '0;
    end else if (cap_en) begin
      kind_q <= kind_in;
      arg_q  <= arg_in;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign hang = (state_q == S_HANG);

  p_hang_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hang |-> busy);

  p_hang_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hang && !clr_pipe) |=> hang);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !clr_pipe) |=> busy);

endmodule

// File: rtl/cpcmd_regs.sv
module cpcmd_regs
  import cpcmd_pkg::*;
#(
  parameter int FLAG_W   = 4,
  parameter int MODE_W   = 4,
  parameter int MAX_MODE = 7,
  localparam int ST_W    = FLAG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_restore,
  input  logic              do_mode,
  input  logic              do_unimpl,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic [ST_W-1:0]   status_q,
  output logic [MODE_W-1:0] mode_q
);

  logic [ST_W-1:0] status_d;
  logic            status_en;

  assign status_en = do_restore || do_unimpl;

  always_comb begin
    status_d = status_q;
    if (do_restore) begin
      status_d            = {flag_in, 2'b00};
      status_d[ST_VALID]  = 1'b1;
    end else if (do_unimpl) begin
      status_d[ST_UNIMPL] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (do_mode) mode_q <= mode_in;
  end

  p_restore_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_restore |=> (status_q[ST_VALID] && !status_q[ST_UNIMPL]));

  p_mode_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ((mode_q != '0) && (32'(mode_q) <= MAX_MODE)));

endmodule

// File: rtl/cpcmd_ctrl.sv
module cpcmd_ctrl
  import cpcmd_pkg::*;
#(
  parameter int ARG_W    = 32,
  parameter int FLAG_W   = 4,
  parameter int FLAG_LSB = 8,
  parameter int MODE_W   = 4,
  parameter int MAX_MODE = 7,
  parameter int NPAT     = DEF_NPAT,
  parameter logic [NPAT-1:0][OP_W-1:0] INV_VAL = DEF_INV_VAL,
  parameter logic [NPAT-1:0][OP_W-1:0] INV_MSK = DEF_INV_MSK,
  localparam int ST_W    = FLAG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              clr_pipe,
  output logic [ST_W-1:0]   status_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              busy,
  output logic              hang
);

  kind_e            kind;
  logic [ARG_W-1:0] arg_q;
  logic             do_restore, do_mode, do_unimpl;

  cpcmd_classify #(
    .NPAT(NPAT), .INV_VAL(INV_VAL), .INV_MSK(INV_MSK)
  ) i_classify (
    .op   (cmd_op),
    .kind (kind)
  );

  cpcmd_fsm #(
    .ARG_W(ARG_W), .MAX_MODE(MAX_MODE)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .kind_in    (kind),
    .arg_in     (cmd_arg),
    .clr_pipe   (clr_pipe),
    .arg_q      (arg_q),
    .do_restore (do_restore),
    .do_mode    (do_mode),
    .do_unimpl  (do_unimpl),
    .busy       (busy),
    .hang       (hang)
  );

  cpcmd_regs #(
    .FLAG_W(FLAG_W), .MODE_W(MODE_W), .MAX_MODE(MAX_MODE)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_restore (do_restore),
    .do_mode    (do_mode),
    .do_unimpl  (do_unimpl),
    .flag_in    (arg_q[FLAG_LSB +: FLAG_W]),
    .mode_in    (arg_q[MODE_W-1:0]),
    .status_q   (status_q),
    .mode_q     (mode_q)
  );

  p_forced_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op[OP_W-1:1] == 11'h1DF) |-> (kind == K_INVALID));

  p_unimpl_hang_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_unimpl |=> (hang && status_q[ST_UNIMPL]));

endmodule

// File: tb/test_cpcmd_ctrl.sv
module test_cpcmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [11:0] cmd_op;
  logic [31:0] cmd_arg;
  logic        clr_pipe;
  logic [5:0]  status_q;
  logic [3:0]  mode_q;
  logic        busy;
  logic        hang;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cpcmd_ctrl i_cpcmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .clr_pipe(clr_pipe), .status_q(status_q),
    .mode_q(mode_q), .busy(busy), .hang(hang)
  );

  typedef struct {
    string      tag;
    logic [5:0] st;
    logic [3:0] md;
    logic       hg;
  } exp_t;

  exp_t sb[$];

  // reference model state
  logic [5:0] m_st;
  logic [3:0] m_md;
  logic       m_hg;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit bad_op(input logic [11:0] op);
    casez (op)
      12'b00111011111?, 12'b1010????????, 12'b?01111??????,
      12'b10111000????, 12'b10111001????, 12'b100????????0,
      12'b00101001010?, 12'b001001110000, 12'b110000000000,
      12'b0111011?????: return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  task automatic model(input logic [11:0] op, input logic [31:0] arg);
    if (m_hg) return;
    if (bad_op(op)) begin
      m_st[1] = 1'b1;
      m_hg    = 1'b1;
    end else if (op == 12'h256) begin
      m_st = {arg[11:8], 2'b01};
    end else if (op[11:1] == 11'h11A) begin
      if (arg != 0 && arg <= 32'd7) m_md = arg[3:0];
      else m_hg = 1'b1;
    end
  endtask

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.st = m_st; e.md = m_md; e.hg = m_hg;
    sb.push_back(e);
  endtask

  task automatic send(input logic [11:0] op, input logic [31:0] arg,
                      input string tag);
    bit was_hang;
    was_hang = m_hg;
    model(op, arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!was_hang)
      chk(busy == 1'b1, {tag, " R10 busy after capture"}, 32'(busy), 1);
    @(negedge clk);
    push(tag);
    @(negedge clk);
  endtask

  task automatic clear(input string tag);
    @(negedge clk);
    clr_pipe = 1'b1;
    @(negedge clk);
    clr_pipe = 1'b0;
    m_hg = 1'b0;
    chk(hang == 1'b0 && busy == 1'b0, {tag, " R8 clr_pipe releases"},
        {30'd0, hang, busy}, 0);
    push({tag, " R8 state kept after clear"});
    @(negedge clk);
  endtask

  // monitor: compare design outputs with queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(status_q == e.st, {e.tag, " status"}, 32'(status_q), 32'(e.st));
        chk(mode_q == e.md, {e.tag, " mode"}, 32'(mode_q), 32'(e.md));
        chk(hang == e.hg, {e.tag, " hang"}, 32'(hang), 32'(e.hg));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0; clr_pipe = 1'b0;
    m_st = '0; m_md = '0; m_hg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(status_q == 0 && mode_q == 0 && !busy && !hang, "R1 reset state",
        {22'd0, status_q, mode_q}, 0);

    send(12'h256, 32'h0000_0A00, "R2 restore flags A");
    send(12'h25E, 32'hFFFF_FFFF, "R3 init no effect");
    send(12'h234, 32'd5, "R4 mode 5");
    send(12'h235, 32'd7, "R4 mode max with lsb 1");
    send(12'h234, 32'd1, "R4 mode min");
    send(12'h234, 32'd0, "R5 mode zero");
    clear("R5a");
    send(12'h235, 32'd8, "R5 mode max plus one");
    clear("R5b");
    send(12'h234, 32'h0001_0001, "R5 mode high bits set");
    clear("R5c");
    send(12'h803, 32'h0000_0F00, "R9 other opcode");
    send(12'h3BE, 32'd0, "R7 forced invalid 3BE");
    send(12'h256, 32'h0000_0500, "R8 ignored while hung");
    chk(busy == 1'b1, "R8 busy while hung", 32'(busy), 1);
    clear("R7a");
    send(12'h256, 32'h0000_0300, "R2 restore clears unimpl");
    send(12'h3BF, 32'd0, "R7 forced invalid 3BF");
    clear("R7b");
    send(12'hA5A, 32'd0, "R6 invalid class 1010");
    clear("R6a");
    send(12'hBC5, 32'd0, "R7 invalid class x01111");
    clear("R7c");
    send(12'h802, 32'd0, "R7 invalid class 100 lsb0");
    clear("R7d");
    send(12'hB84, 32'd0, "R7 invalid class 10111000");
    clear("R7e");
    send(12'hB9F, 32'd0, "R7 invalid class 10111001");
    clear("R7f");
    send(12'h256, 32'h0000_0C00, "R2 restore flags C");

    // R10: second strobe during execute cycle is dropped
    model(12'h256, 32'h0000_0600);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 12'h256; cmd_arg = 32'h0000_0600;
    @(negedge clk);
    cmd_op = 12'h234; cmd_arg = 32'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    push("R10 strobe while busy dropped");
    @(negedge clk);

    // R8: clr_pipe in the execute cycle cancels the command
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 12'h256; cmd_arg = 32'h0000_0F00;
    @(negedge clk);
    cmd_valid = 1'b0; clr_pipe = 1'b1;
    @(negedge clk);
    clr_pipe = 1'b0;
    push("R8 clr_pipe cancels in flight");
    @(negedge clk);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule